// File: doc/BRIEF.md
# Linked Transfer Descriptor Sequencer

This block walks a chain of transfer descriptors kept in system memory and feeds them, one at a time, to a serial transfer engine. A descriptor occupies 24 bytes: a start-configuration word, a bus-configuration word, a 64-bit transmit buffer address and a 64-bit receive buffer address. The sequencer reads the six words of a descriptor through a simple single-word read port. It presents them to the engine with a one-cycle start pulse and waits for the engine's done pulse. It then moves on to the descriptor 24 bytes further on, until it has finished one whose end-of-chain flag is set.

Software owns the block through eight 32-bit registers: an ownership semaphore, a trigger configuration, the two halves of the chain pointer, the two halves of the current-descriptor address, interrupt status and interrupt enable. A chain starts either at once, when the pending flag is written into the upper pointer register, or on a chosen edge of an external sync input once it has been armed. Writing zero to the upper pointer register abandons the chain. Fetch errors, malformed descriptors and fault flags reported by the engine stop the chain and are recorded in the status register. The single interrupt line is the OR of the enabled status bits.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset the semaphore (register 0) reads 1, interrupt status (register 6) and enable (register 7) read 0, `irq` is 0 and `mem_req` is 0.
- R2: A read of register 0 returns the semaphore bit in bit 0 and leaves it 0. Writing 1 to register 0 sets it to 1 again and sets status bit 9.
- R3: With both trigger bits clear, writing register 3 (upper pointer) with bit 31 set while idle starts fetching at the address {register3[30:0], register2}. The six words are read in ascending order at offsets 0, 4, 8, 12, 16 and 20.
- R4: After the sixth word of a descriptor arrives, `eng_start` is high for exactly one cycle. During that cycle `eng_cfg_start` = word 0, `eng_cfg_bus` = word 1, `eng_tx_addr` = {word 3, word 2} and `eng_rx_addr` = {word 5, word 4}.
- R5: After `eng_done`, the next descriptor is fetched 24 bytes further on, with the carry into the upper 32 bits, unless bit 30 (end of chain) of the start word was set.
- R6: Status bit 10 is set for every completed descriptor. Status bit 11 is set once, when the end-of-chain descriptor completes.
- R7: Writing 1 to a bit of register 6 clears that status bit. `irq` is the OR of (status AND register 7).
- R8: If bit 6 (rising) or bit 7 (falling) of register 1 is set, a register 3 write with bit 31 set only arms the sequencer. The chain starts on the next selected edge of `sync_in`, and later edges do nothing until the sequencer is armed again.
- R9: Writing 0 to register 3 aborts the chain: fetching stops, no further `eng_start` is issued, and no done status is recorded for the aborted chain.
- R10: A fetch answered with `mem_err`, or a start word whose bit 31 (valid) is clear, sets status bit 8 and stops the chain.
- R11: The `eng_fault` flags present with `eng_done` are ORed into status bits 7:0. A nonzero value stops the chain without setting bit 11.
- R12: Registers 4 and 5 return the lower and upper halves of the address of the descriptor being (or last) fetched or executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on register 0) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_err | input | 1 | Error response accompanying mem_ack |
| mem_rdata | input | 32 | Read data |
| eng_start | output | 1 | One-cycle start pulse to the transfer engine |
| eng_cfg_start | output | 32 | Start-configuration word of the current descriptor |
| eng_cfg_bus | output | 32 | Bus-configuration word of the current descriptor |
| eng_tx_addr | output | 64 | Transmit buffer address |
| eng_rx_addr | output | 64 | Receive buffer address |
| eng_done | input | 1 | Engine completion pulse |
| eng_fault | input | 8 | Engine fault flags, valid with eng_done |
| sync_in | input | 1 | External start synchronisation input |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default address width of 64 bits. This lets it place a chain just below a 4 GiB boundary, so the 24-byte step must carry into the upper pointer half and the current-descriptor readback. A memory model with random latency and an engine model with random completion delay give every fetch and every execution phase variable timing. A slow engine setting keeps an abort inside the execution phase.

// File: rtl/desc_chain_seq.sv
module desc_chain_seq #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          eng_start,
  output logic [31:0]   eng_cfg_start,
  output logic [31:0]   eng_cfg_bus,
  output logic [63:0]   eng_tx_addr,
  output logic [63:0]   eng_rx_addr,
  input  logic          eng_done,
  input  logic [7:0]    eng_fault,
  input  logic          sync_in,
  output logic          irq
);
  localparam int NWORDS = 6;
  localparam logic [AW-1:0] STEP = AW'(NWORDS * 4);
  localparam logic [2:0] A_SEM = 3'd0, A_CFG = 3'd1, A_PLO = 3'd2, A_PHI = 3'd3,
                         A_CLO = 3'd4, A_CHI = 3'd5, A_STS = 3'd6, A_IEN = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} st_t;
  st_t st;

  logic [2:0]    widx;
  logic [31:0]   dw [NWORDS];
  logic [AW-1:0] cur;
  logic [31:0]   ptr_lo, ptr_hi, spi_cfg;
  logic [11:0]   stat, ien, stat_set, stat_clr;
  logic          sem, armed, sync_q;

  wire wr_hi    = reg_wr && reg_addr == A_PHI;
  wire abort    = wr_hi && reg_wdata == 32'd0;
  wire trig_en  = spi_cfg[6] | spi_cfg[7];
  wire edge_hit = (spi_cfg[6] & sync_in & ~sync_q) | (spi_cfg[7] & ~sync_in & sync_q);
  wire go_sw    = st == S_IDLE && wr_hi && reg_wdata[31] && !trig_en;
  wire go_hw    = st == S_IDLE && armed && edge_hit && !wr_hi;
  wire [AW-1:0] start_ptr = AW'({(go_sw ? reg_wdata[30:0] : ptr_hi[30:0]), ptr_lo});
  wire last_word = widx == 3'(NWORDS - 1);
  wire fetch_bad = st == S_FETCH && mem_ack && (mem_err || (widx == 3'd0 && !mem_rdata[31]));
  wire exec_end  = st == S_EXEC && eng_done && !eng_start;
  wire faulted   = |eng_fault;
  wire [63:0] cur64 = 64'(cur);

  assign mem_req       = st == S_FETCH;
  assign mem_addr      = cur + AW'({widx, 2'b00});
  assign eng_cfg_start = dw[0];
  assign eng_cfg_bus   = dw[1];
  assign eng_tx_addr   = {dw[3], dw[2]};
  assign eng_rx_addr   = {dw[5], dw[4]};
  assign irq           = |(stat & ien);

  always_comb begin
    stat_set = '0;
    if (!abort) begin
      stat_set[7:0] = exec_end ? eng_fault : 8'd0;
      stat_set[8]   = fetch_bad;
      stat_set[10]  = exec_end;
      stat_set[11]  = exec_end && !faulted && dw[0][30];
    end
    stat_set[9] = reg_wr && reg_addr == A_SEM && reg_wdata[0];
    stat_clr = (reg_wr && reg_addr == A_STS) ? reg_wdata[11:0] : 12'd0;
  end

  always_comb begin
    case (reg_addr)
      A_SEM:   reg_rdata = {31'd0, sem};
      A_CFG:   reg_rdata = spi_cfg;
      A_PLO:   reg_rdata = ptr_lo;
      A_PHI:   reg_rdata = ptr_hi;
      A_CLO:   reg_rdata = cur64[31:0];
      A_CHI:   reg_rdata = cur64[63:32];
      A_STS:   reg_rdata = {20'd0, stat};
      default: reg_rdata = {20'd0, ien};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sem <= 1'b1; spi_cfg <= '0; ptr_lo <= '0; ptr_hi <= '0;
      stat <= '0; ien <= '0; armed <= 1'b0; sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
      stat   <= (stat & ~stat_clr) | stat_set;
      if (reg_rd && reg_addr == A_SEM) sem <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          A_SEM:   sem <= reg_wdata[0];
          A_CFG:   spi_cfg <= reg_wdata;
          A_PLO:   ptr_lo <= reg_wdata;
          A_PHI:   ptr_hi <= reg_wdata;
          A_IEN:   ien <= reg_wdata[11:0];
          default: ;
        endcase
      end
      if (abort)                                   armed <= 1'b0;
      else if (wr_hi && reg_wdata[31] && trig_en)  armed <= 1'b1;
      else if (go_hw)                              armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; cur <= '0; eng_start <= 1'b0;
      for (int i = 0; i < NWORDS; i++) dw[i] <= '0;
    end else begin
      eng_start <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (go_sw || go_hw) begin
            st <= S_FETCH; cur <= start_ptr; widx <= '0;
          end
          S_FETCH: if (mem_ack) begin
            if (fetch_bad) st <= S_IDLE;
            else begin
              dw[widx] <= mem_rdata;
              if (last_word) begin st <= S_EXEC; eng_start <= 1'b1; end
              else widx <= widx + 3'd1;
            end
          end
          S_EXEC: if (exec_end) begin
            if (faulted || dw[0][30]) st <= S_IDLE;
            else begin st <= S_FETCH; cur <= cur + STEP; widx <= '0; end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R4
  AST_START_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(mem_ack) && !$past(mem_err)); // R4
  AST_CHAIN_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[11]) |-> $past(eng_done)); // R6
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !mem_req && !eng_start); // R9
  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[8]) |-> !mem_req && !eng_start); // R10
  AST_SEM_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_SEM && !reg_wr) |=> !sem); // R2
endmodule

// File: tb/sim_desc_chain_seq.sv
`timescale 1ns/1ps
module sim_desc_chain_seq;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_ack = 0, mem_err = 0;
  logic [63:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic eng_start, eng_done = 0;
  logic [7:0] eng_fault = 0;
  logic [31:0] eng_cfg_start, eng_cfg_bus;
  logic [63:0] eng_tx_addr, eng_rx_addr;
  logic sync_in = 0, irq;

  always #2 clk = ~clk;

  desc_chain_seq #(.AW(64)) u0 (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_addr, .mem_ack, .mem_err, .mem_rdata,
    .eng_start, .eng_cfg_start, .eng_cfg_bus, .eng_tx_addr, .eng_rx_addr,
    .eng_done, .eng_fault, .sync_in, .irq);

  int total = 0, bad = 0;
  logic [31:0] mem [logic [63:0]];
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
  int mwait = 0, eng_cnt = 0;
  bit eng_slow = 0;
  logic [7:0] fault_val = 0;
  logic [31:0] lg_s [16], lg_b [16];
  logic [63:0] lg_tx [16], lg_rx [16];
  int lg_n = 0;
  logic [31:0] ex_s [8], ex_b [8];
  logic [63:0] ex_tx [8], ex_rx [8];

  always @(negedge clk) begin
    mem_ack = 0; mem_err = 0;
    if (rst_n && mem_req) begin
      if (mwait > 0) mwait--;
      else begin
        mem_ack = 1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
        mem_err = (mem_addr == err_addr);
        mwait = $urandom % 3;
      end
    end
  end

  always @(negedge clk) begin
    eng_done = 0; eng_fault = 0;
    if (!rst_n) eng_cnt = 0;
    else if (eng_start) begin
      if (lg_n < 16) begin
        lg_s[lg_n] = eng_cfg_start; lg_b[lg_n] = eng_cfg_bus;
        lg_tx[lg_n] = eng_tx_addr; lg_rx[lg_n] = eng_rx_addr;
      end
      lg_n++;
      eng_cnt = eng_slow ? 60 : 1 + $urandom % 4;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin eng_done = 1; eng_fault = fault_val; end
    end
  end

  function automatic logic [63:0] desc_at(logic [63:0] base, int i);
    return base + 64'(24 * i);
  endfunction

  function automatic logic [31:0] done_status(int ndone, bit chain_end, logic [7:0] flt, bit derr);
    logic [31:0] s = {24'd0, flt};
    if (ndone > 0) s[10] = 1;
    if (chain_end) s[11] = 1;
    if (derr) s[8] = 1;
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  task automatic build(input logic [63:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      logic [63:0] a = desc_at(base, i);
      ex_s[i] = $urandom; ex_s[i][31] = 1'b1; ex_s[i][30] = (i == n - 1);
      ex_b[i] = $urandom;
      ex_tx[i] = {$urandom, $urandom}; ex_rx[i] = {$urandom, $urandom};
      mem[a] = ex_s[i]; mem[a + 4] = ex_b[i];
      mem[a + 8] = ex_tx[i][31:0]; mem[a + 12] = ex_tx[i][63:32];
      mem[a + 16] = ex_rx[i][31:0]; mem[a + 20] = ex_rx[i][63:32];
    end
  endtask

  task automatic launch(input logic [63:0] base);
    wr(3'd2, base[31:0]);
    wr(3'd3, {1'b1, base[62:32]});
  endtask

  task automatic clear_sts();
    wr(3'd6, 32'hFFF);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] base;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rd(3'd6, d); chk("R1 status after reset", d, 0);
    rd(3'd7, d); chk("R1 enable after reset", d, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 mem_req after reset", mem_req, 0);
    rd(3'd0, d); chk("R1 semaphore free after reset", d, 1);

    rd(3'd0, d); chk("R2 semaphore taken by read", d, 0);
    wr(3'd0, 1);
    rd(3'd6, d); chk("R2 release sets status bit 9", d, 32'h200);
    rd(3'd0, d); chk("R2 semaphore free after release", d, 1);
    clear_sts();
    rd(3'd6, d); chk("R7 write-one clears status", d, 0);

    wr(3'd7, 32'h800);
    for (int t = 0; t < 6; t++) begin
      n = 1 + $urandom % 4;
      base = {29'(t), 3'd0, $urandom & 32'hFFFF_FFFC};
      lg_n = 0;
      build(base, n);
      launch(base);
      wait_irq();
      cycles(2);
      chk("R5 descriptors executed", lg_n, n);
      for (int i = 0; i < n; i++) begin
        chk("R4 start word to engine", lg_s[i], ex_s[i]);
        chk("R4 bus word to engine", lg_b[i], ex_b[i]);
        chk("R3 tx address to engine", lg_tx[i], ex_tx[i]);
        chk("R3 rx address to engine", lg_rx[i], ex_rx[i]);
      end
      rd(3'd6, d); chk("R6 done and chain-done status", d, done_status(n, 1, 0, 0));
      rd(3'd4, d); chk("R12 current descriptor low", d, desc_at(base, n - 1) & 64'hFFFF_FFFF);
      rd(3'd5, d); chk("R12 current descriptor high", d, desc_at(base, n - 1) >> 32);
      clear_sts();
      chk("R7 irq drops after clear", irq, 0);
    end

    base = 64'h0000_0003_FFFF_FFF0;
    lg_n = 0; build(base, 2); launch(base); wait_irq(); cycles(2);
    chk("R5 carry chain length", lg_n, 2);
    chk("R5 carry second descriptor", lg_tx[1], ex_tx[1]);
    rd(3'd5, d); chk("R12 carry current high", d, 32'h4);
    rd(3'd4, d); chk("R12 carry current low", d, 32'h8);
    clear_sts();

    wr(3'd7, 0);
    base = 64'h1000; lg_n = 0; build(base, 1); launch(base);
    cycles(100);
    chk("R7 masked irq stays low", irq, 0);
    rd(3'd6, d); chk("R7 status set while masked", d, done_status(1, 1, 0, 0));
    wr(3'd7, 32'h800);
    #1 chk("R7 irq follows enable", irq, 1);
    clear_sts();

    wr(3'd1, 32'h40);
    base = 64'h2000; lg_n = 0; build(base, 2); launch(base);
    cycles(20);
    chk("R8 armed but not started", lg_n, 0);
    chk("R8 no fetch before edge", mem_req, 0);
    @(negedge clk) sync_in = 1;
    wait_irq(); cycles(2);
    chk("R8 rising edge runs chain", lg_n, 2);
    @(negedge clk) sync_in = 0;
    cycles(5);
    @(negedge clk) sync_in = 1;
    cycles(50);
    chk("R8 edge without arming ignored", lg_n, 2);
    clear_sts();
    wr(3'd1, 32'h80);
    base = 64'h3000; lg_n = 0; build(base, 1); launch(base);
    cycles(20);
    chk("R8 falling mode waits", lg_n, 0);
    @(negedge clk) sync_in = 0;
    wait_irq(); cycles(2);
    chk("R8 falling edge runs chain", lg_n, 1);
    wr(3'd1, 0);
    clear_sts();

    eng_slow = 1;
    base = 64'h4000; lg_n = 0; build(base, 3); launch(base);
    for (int i = 0; i < 500 && lg_n == 0; i++) @(negedge clk);
    wr(3'd3, 0);
    cycles(200);
    chk("R9 no start after abort", lg_n, 1);
    chk("R9 fetch idle after abort", mem_req, 0);
    rd(3'd6, d); chk("R9 no done status after abort", d, 0);
    eng_slow = 0;
    clear_sts();

    base = 64'h5000; lg_n = 0; build(base, 2);
    err_addr = desc_at(base, 1) + 8;
    launch(base); cycles(300);
    rd(3'd6, d); chk("R10 fetch error status", d, done_status(1, 0, 0, 1));
    chk("R10 chain stops at error", lg_n, 1);
    err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
    clear_sts();

    base = 64'h6000; lg_n = 0; build(base, 1);
    mem[base] = mem[base] & 32'h7FFF_FFFF;
    launch(base); cycles(200);
    rd(3'd6, d); chk("R10 invalid descriptor status", d, done_status(0, 0, 0, 1));
    chk("R10 invalid descriptor not executed", lg_n, 0);
    clear_sts();

    fault_val = 8'h08;
    base = 64'h7000; lg_n = 0; build(base, 3); launch(base); cycles(300);
    rd(3'd6, d); chk("R11 engine fault status", d, done_status(1, 0, 8'h08, 0));
    chk("R11 chain stops on fault", lg_n, 1);
    fault_val = 0;
    clear_sts();

    summary();
    $finish;
  end
endmodule